// File: doc/BRIEF.md
# Line-Scan CCD Drive Pulse Generator

This block turns a fast system clock into the digital drive pulses for a linear CCD sensor that has an on-chip transfer register and an electronic shutter. When a line is requested, it first keeps the pixel clock parked low for a guard interval. It then raises the readout gate, which moves the accumulated charge into the transfer register. After a second guard interval it runs the pixel clock for one full line of shifts.

An active-low shutter output dumps the photo charge to the drain during the early part of each line readout. It releases a programmable number of pixel periods before the line ends, which sets the exposure of the next line. A mode input enables an external reset pulse that follows each falling edge of the pixel clock. A pixel index and a line-valid strobe mark each shifted pixel for the downstream capture logic.

Every guard and pulse width is given in nanoseconds and converted to system-clock cycles, rounded up, from the configured clock frequency. A minimum time therefore holds whatever the clock rate. All outputs come from registers.

Top module: `ccd_line_timer`

## Requirements
- R1: After each readout gate pulse the pixel clock makes exactly LINE_PIX rising edges. The next readout gate rises only after the last of those pixels has ended.
- R2: Within a line, each pixel clock high phase and each low phase lasts exactly PIX_HALF system-clock cycles. Outside a line the pixel clock stays low.
- R3: The readout gate is high for exactly ceil(ROG_NS × CLK_KHZ / 10^6) cycles. The pixel clock and line-valid are low while it is high.
- R4: The pixel clock is low for at least GUARD_CYC = ceil(GUARD_NS × CLK_KHZ / 10^6) cycles before the readout gate rises. The readout gate is low for at least GUARD_CYC cycles before the first pixel clock rise.
- R5: `int_time` is in pixel periods. Let the effective value e be min(int_time, LINE_PIX). `shut_n` is low (dumping) during pixels 1 to LINE_PIX−e and high during the last e pixels. It is also high outside a line. With e = LINE_PIX the shutter never goes low.
- R6: `int_time` is captured when a line starts. A change during that line has no effect on its shutter window.
- R7: A request that arrives while a line is in progress is held. It starts one further line after the current one ends. Several requests during one line start only one further line.
- R8: `pix_idx` is 1 from the first pixel clock rise of a line. It steps by one on each rise, up to LINE_PIX. `line_valid` is high exactly while `pix_idx` is nonzero, and `pix_idx` is 0 outside a line.
- R9: With `ext_rs_mode` = 1, `ext_rs` goes high in the cycle the pixel clock falls. It stays high for ceil(RS_NS × CLK_KHZ / 10^6) cycles and is low for at least that many cycles before the next pixel clock rise. With `ext_rs_mode` = 0, `ext_rs` stays low.
- R10: During reset: pix_clk=0, rd_gate=0, shut_n=1, ext_rs=0, pix_idx=0, line_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_req | input | 1 | Request one line readout (one-cycle pulse) |
| ext_rs_mode | input | 1 | 1 selects external reset pulse generation |
| int_time | input | IW | Exposure in pixel periods, captured at line start |
| pix_clk | output | 1 | Pixel shift clock |
| rd_gate | output | 1 | Readout gate pulse |
| shut_n | output | 1 | Shutter drive, low dumps charge |
| ext_rs | output | 1 | External reset pulse |
| pix_idx | output | IW | Index of the pixel being shifted, 0 when idle |
| line_valid | output | 1 | High while a pixel of the line is shifted |

## Verification
Two events can land in the same cycle: a new line request and the running readout, including its final cycle, when the state machine returns to idle. The bench provokes this by pulsing the request twice in the middle of a line. It judges the outcome by counting readout gate pulses afterwards: exactly one extra line must follow, and its gate must rise only after line-valid has fallen. A similar overlap exists between exposure capture and a register change: `int_time` is rewritten mid-line, and the shutter window of that line is compared with the value present at the request. A full sweep of `int_time` over every code in both reset modes checks the shutter boundaries at zero, at LINE_PIX and above it.

// File: rtl/ccd_line_timer.sv
module ccd_line_timer #(
  parameter int CLK_KHZ  = 125000,
  parameter int LINE_PIX = 2087,
  parameter int PIX_HALF = 16,
  parameter int GUARD_NS = 500,
  parameter int ROG_NS   = 1000,
  parameter int RS_NS    = 50,
  parameter int IW       = $clog2(LINE_PIX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_req,
  input  logic          ext_rs_mode,
  input  logic [IW-1:0] int_time,
  output logic          pix_clk,
  output logic          rd_gate,
  output logic          shut_n,
  output logic          ext_rs,
  output logic [IW-1:0] pix_idx,
  output logic          line_valid
);

  localparam int GUARD_RAW = (GUARD_NS * CLK_KHZ + 999999) / 1000000;
  localparam int ROG_RAW   = (ROG_NS * CLK_KHZ + 999999) / 1000000;
  localparam int RS_RAW    = (RS_NS * CLK_KHZ + 999999) / 1000000;
  localparam int GUARD_CYC = (GUARD_RAW < 1) ? 1 : GUARD_RAW;
  localparam int ROG_CYC   = (ROG_RAW < 1) ? 1 : ROG_RAW;
  localparam int RS_CYC    = (RS_RAW < 1) ? 1 : RS_RAW;
  localparam int CNT_MAX   = (GUARD_CYC > ROG_CYC) ? GUARD_CYC : ROG_CYC;
  localparam int CW        = $clog2(CNT_MAX + 1);
  localparam int HW        = (PIX_HALF > 1) ? $clog2(PIX_HALF) : 1;

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_GATE, S_POST, S_READ} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [HW-1:0] hc;
  logic          ph;
  logic [IW-1:0] pix;
  logic [IW-1:0] intl;
  logic          pend;

  wire           in_read  = (st == S_READ);
  wire           half_end = (int'(hc) == PIX_HALF - 1);
  wire [IW-1:0]  int_clip = (int'(int_time) > LINE_PIX) ? IW'(LINE_PIX) : int_time;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      hc   <= '0;
      ph   <= 1'b0;
      pix  <= '0;
      intl <= '0;
      pend <= 1'b0;
    end else begin
      if (line_req && st != S_IDLE) pend <= 1'b1;
      case (st)
        S_IDLE: if (line_req || pend) begin
          st   <= S_PRE;
          cnt  <= '0;
          pend <= 1'b0;
          intl <= int_clip;
        end
        S_PRE: if (int'(cnt) == GUARD_CYC - 1) begin
          st  <= S_GATE;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        S_GATE: if (int'(cnt) == ROG_CYC - 1) begin
          st  <= S_POST;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        S_POST: if (int'(cnt) == GUARD_CYC - 1) begin
          st  <= S_READ;
          cnt <= '0;
          hc  <= '0;
          ph  <= 1'b1;
          pix <= IW'(1);
        end else cnt <= cnt + 1'b1;
        S_READ: if (half_end) begin
          hc <= '0;
          if (ph) ph <= 1'b0;
          else if (int'(pix) == LINE_PIX) begin
            st  <= S_IDLE;
            pix <= '0;
          end else begin
            ph  <= 1'b1;
            pix <= pix + 1'b1;
          end
        end else hc <= hc + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_clk    <= 1'b0;
      rd_gate    <= 1'b0;
      shut_n     <= 1'b1;
      ext_rs     <= 1'b0;
      pix_idx    <= '0;
      line_valid <= 1'b0;
    end else begin
      pix_clk    <= in_read && ph;
      rd_gate    <= (st == S_GATE);
      shut_n     <= !in_read || (int'(pix) + int'(intl) > LINE_PIX);
      ext_rs     <= ext_rs_mode && in_read && !ph && (int'(hc) < RS_CYC);
      pix_idx    <= in_read ? pix : '0;
      line_valid <= in_read;
    end
  end

  logic [CW-1:0] chk_clk_low, chk_gate_low;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_clk_low  <= CW'(GUARD_CYC);
      chk_gate_low <= CW'(GUARD_CYC);
    end else begin
      if (pix_clk) chk_clk_low <= '0;
      else if (int'(chk_clk_low) < GUARD_CYC) chk_clk_low <= chk_clk_low + 1'b1;
      if (rd_gate) chk_gate_low <= '0;
      else if (int'(chk_gate_low) < GUARD_CYC) chk_gate_low <= chk_gate_low + 1'b1;
    end
  end

  a_r4_idle_before_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_gate) |-> int'(chk_clk_low) >= GUARD_CYC);
  a_r4_idle_after_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_clk) |-> int'(chk_gate_low) >= GUARD_CYC);
  a_r3_gate_excl: assert property (@(posedge clk) disable iff (!rst_n)
    rd_gate |-> !pix_clk && !line_valid);
  a_r1_gate_after_line: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_gate) |-> !$past(line_valid));
  a_r2_clk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !line_valid |-> !pix_clk);
  a_r8_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> pix_idx != '0 && int'(pix_idx) <= LINE_PIX);
  a_r8_idx_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !line_valid |-> pix_idx == '0);
  a_r8_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_clk) && $past(line_valid) |-> pix_idx == $past(pix_idx) + IW'(1));
  a_r5_shut_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !line_valid |-> shut_n);
  a_r5_shut_release_once: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid && $past(line_valid) && $past(shut_n) |-> shut_n);
  a_r9_rs_mode: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rs |-> $past(ext_rs_mode) && !pix_clk);

endmodule

// File: tb/ccd_line_timer_bench.sv
module ccd_line_timer_bench;
  localparam int CLK_KHZ = 20000;
  localparam int N = 12;
  localparam int H = 3;
  localparam int G = 10;
  localparam int RG = 20;
  localparam int RS = 1;
  localparam int IW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_req = 1'b0;
  logic ext_rs_mode = 1'b0;
  logic [IW-1:0] int_time = '0;
  logic pix_clk, rd_gate, shut_n, ext_rs, line_valid;
  logic [IW-1:0] pix_idx;

  always #4 clk = ~clk;

  ccd_line_timer #(.CLK_KHZ(CLK_KHZ), .LINE_PIX(N), .PIX_HALF(H),
    .GUARD_NS(500), .ROG_NS(1000), .RS_NS(50)) u_ccd_line_timer (
    .clk(clk), .rst_n(rst_n), .line_req(line_req), .ext_rs_mode(ext_rs_mode),
    .int_time(int_time), .pix_clk(pix_clk), .rd_gate(rd_gate), .shut_n(shut_n),
    .ext_rs(ext_rs), .pix_idx(pix_idx), .line_valid(line_valid));

  int errors = 0, checks = 0;
  int lines_done = 0, gates = 0;
  int exp_int = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  logic p_clk = 0, p_gate = 0, p_rs = 0, p_valid = 0;
  int low_run = 1000, gate_off = 1000, hi_run = 0, lo_in_line = 0;
  int gate_w = 0, rs_w = 0, rs_gap = 1000, pixcnt = 0;
  bit first_pix = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      chk(line_valid || !pix_clk, "R2 idle clock", pix_clk, 0);
      if (rd_gate && !p_gate) begin
        gates++;
        chk(low_run >= G, "R4 low before gate", low_run, G);
        chk(!p_valid, "R1 gate after line", p_valid, 0);
        gate_w = 0;
      end
      if (rd_gate) gate_w++;
      if (!rd_gate && p_gate) begin
        chk(gate_w == RG, "R3 gate width", gate_w, RG);
        pixcnt = 0;
        first_pix = 1;
      end
      if (pix_clk && !p_clk) begin
        if (first_pix) chk(gate_off >= G, "R4 gate low before clock", gate_off, G);
        else chk(lo_in_line == H, "R2 low phase", lo_in_line, H);
        first_pix = 0;
        pixcnt++;
        chk(int'(pix_idx) == pixcnt, "R8 index", pix_idx, pixcnt);
        chk(line_valid, "R8 valid", line_valid, 1);
        chk(shut_n == (pixcnt > N - exp_int), "R5 R6 shutter", shut_n, pixcnt > N - exp_int);
        if (ext_rs_mode) chk(rs_gap >= RS, "R9 gap before rise", rs_gap, RS);
        hi_run = 0;
      end
      if (pix_clk) hi_run++;
      if (!pix_clk && p_clk) begin
        chk(hi_run == H, "R2 high phase", hi_run, H);
        lo_in_line = 0;
      end
      if (!pix_clk && line_valid) lo_in_line++;
      if (ext_rs && !p_rs) begin
        chk(ext_rs_mode, "R9 internal mode quiet", ext_rs, 0);
        chk(p_clk && !pix_clk, "R9 rise at clock fall", p_clk, 1);
        rs_w = 0;
      end
      if (ext_rs) rs_w++;
      if (!ext_rs && p_rs) begin
        chk(rs_w == RS, "R9 width", rs_w, RS);
        rs_gap = 0;
      end
      if (!ext_rs) rs_gap++;
      if (!line_valid && p_valid) begin
        chk(pixcnt == N, "R1 pixels per line", pixcnt, N);
        chk(pix_idx == '0, "R8 index cleared", pix_idx, 0);
        chk(shut_n, "R5 shutter idle", shut_n, 1);
        lines_done++;
      end
      low_run  = pix_clk ? 0 : low_run + 1;
      gate_off = rd_gate ? 0 : gate_off + 1;
    end
    p_clk = pix_clk; p_gate = rd_gate; p_rs = ext_rs; p_valid = line_valid;
  end

  task automatic request();
    @(negedge clk) line_req = 1'b1;
    @(negedge clk) line_req = 1'b0;
  endtask

  task automatic run_line(input int v);
    int tgt;
    tgt = lines_done + 1;
    @(negedge clk);
    int_time = IW'(v);
    exp_int = (v > N) ? N : v;
    request();
    wait (lines_done == tgt);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(!pix_clk && !rd_gate && shut_n && !ext_rs && pix_idx == '0 && !line_valid,
        "R10 reset state", {pix_clk, rd_gate, shut_n, ext_rs, line_valid}, 5'b00100);
    @(negedge clk) rst_n = 1'b1;
    for (int m = 0; m < 2; m++) begin
      ext_rs_mode = m[0];
      for (int v = 0; v < (1 << IW); v++) run_line(v);
    end
    ext_rs_mode = 1'b0;
    begin
      int tgt;
      tgt = lines_done + 1;
      int_time = IW'(3);
      exp_int = 3;
      request();
      wait (line_valid);
      repeat (5) @(negedge clk);
      int_time = IW'(10);
      wait (lines_done == tgt);
      repeat (3) @(negedge clk);
    end
    begin
      int g0, tgt;
      int_time = IW'(5);
      exp_int = 5;
      g0 = gates;
      tgt = lines_done + 2;
      request();
      wait (line_valid);
      repeat (7) @(negedge clk);
      request();
      repeat (4) @(negedge clk);
      request();
      wait (lines_done == tgt);
      repeat (300) @(negedge clk);
      chk(gates == g0 + 2, "R7 one queued line", gates - g0, 2);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule